// File: doc/BRIEF.md
# Per-Task Banked Register File with Kernel Window Access

This block holds the general registers of a processor that keeps one bank of 32 registers for each task. A window number selects the bank. The processor pipeline reaches only the active bank, through two read ports and one write port. Window 0 belongs to the kernel and to interrupt and exception handling. Windows 1 and up belong to user tasks.

A second path makes the block look like memory. In kernel mode, load/store instructions can reach every cell of every bank through this path. In user mode, any access on this path is refused. The refused access turns into a privilege trap: the block switches to kernel mode and window 0, and it records a cause code. The block also keeps the window to return to, so that a trap return resumes the task.

The storage behaves as synchronous block RAM and its contents are not cleared by reset. The window-number width is a parameter. The full configuration is 8 bits: 256 windows mapped over byte addresses 0x0000..0x7FFF. The default elaborates 6 bits to keep the array small.

Top module: `winreg_file`

## Requirements
- R1: After reset the block is in kernel mode, with active window 0 and saved window 0. `fault_o` and `mm_ack_o` are low.
- R2: Pipeline reads and writes address register `idx` of the active window. Read data appears one clock after the index is presented.
- R3: Suppose a read and a write address the same cell in the same cycle. The read then returns the newly written value.
- R4: A kernel-mode mapped access at byte address A reaches window A[WIN_W+6:7], register A[6:2]. A read returns its data, and any access raises `mm_ack_o`, one clock later. A write updates the cell.
- R5: A mapped access in user mode does not change the addressed cell and gives no `mm_ack_o`. One clock later `fault_o` pulses and `cause_o` = 1 (privilege). The block is then in kernel mode with window 0, and the saved window holds the window that was active.
- R6: A kernel-mode mapped access with A[1:0] ≠ 0 is not performed. One clock later `fault_o` pulses with `cause_o` = 2 (alignment), and the block enters window 0.
- R7: Suppose a kernel-mode mapped write meets a pipeline write in the same cycle. Then `mm_busy_o` is high in that cycle, the mapped write is dropped with no ack, and the pipeline write is performed.
- R8: `trap_take_i` enters kernel mode and window 0 on the next clock. It saves the previous window and sets `cause_o` = 3 (external). It does not pulse `fault_o`.
- R9: In kernel mode, `ctx_load_i` sets the saved window to `ctx_win_i`. `trap_ret_i` makes the saved window active and enters user mode. In user mode both inputs are ignored.
- R10: Priority in one cycle runs as follows: a trap (fault or `trap_take_i`) first, then `ctx_load_i`, then `trap_ret_i`. A fault's cause wins over the external cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rs1_idx_i | input | 5 | Read port 1 register index |
| rs2_idx_i | input | 5 | Read port 2 register index |
| rs1_data_o | output | 32 | Read port 1 data |
| rs2_data_o | output | 32 | Read port 2 data |
| wr_en_i | input | 1 | Pipeline write enable |
| wr_idx_i | input | 5 | Pipeline write register index |
| wr_data_i | input | 32 | Pipeline write data |
| mm_req_i | input | 1 | Mapped access request |
| mm_we_i | input | 1 | Mapped access is a write |
| mm_addr_i | input | WIN_W+7 | Mapped byte address |
| mm_wdata_i | input | 32 | Mapped write data |
| mm_busy_o | output | 1 | Mapped write stalled this cycle |
| mm_ack_o | output | 1 | Mapped access completed |
| mm_rdata_o | output | 32 | Mapped read data, valid with ack |
| trap_take_i | input | 1 | Interrupt or exception taken |
| trap_ret_i | input | 1 | Return from trap |
| ctx_load_i | input | 1 | Load return window |
| ctx_win_i | input | WIN_W | Return window to load |
| user_mode_o | output | 1 | 1 = user mode |
| cur_win_o | output | WIN_W | Active window |
| saved_win_o | output | WIN_W | Saved return window |
| fault_o | output | 1 | Pulse on a mapped-access fault |
| cause_o | output | 2 | Last trap cause |

## Verification
A wrong active or saved window number shows up on the read ports one clock after the next read. It also shows on `cur_win_o` and `saved_win_o` right after the trap or return that set it. A write sent to the wrong cell stays hidden until that cell is read back, so the bench first fills every cell with known values. It then compares both read ports and every mapped read in every cycle. A protection or stall error is caught in the cycle after the request, through a missing or extra `mm_ack_o`, or later when the cell that should not have changed is read.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
    typedef enum logic [1:0] {
        CAUSE_NONE  = 2'd0,
        CAUSE_PRIV  = 2'd1,
        CAUSE_ALIGN = 2'd2,
        CAUSE_EXT   = 2'd3
    } cause_e;
endpackage

// File: rtl/winreg_ram.sv
// Storage array: one write port, NRD synchronous read ports (read-before-write).
module winreg_ram #(
    parameter int IDX_W = 11,
    parameter int DW    = 32,
    parameter int NRD   = 3
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [IDX_W-1:0]          waddr,
    input  logic [DW-1:0]             wdata,
    input  logic [NRD-1:0][IDX_W-1:0] raddr,
    output logic [NRD-1:0][DW-1:0]    rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            q <= mem[raddr[g]];
        end
        assign rdata[g] = q;
    end
endmodule

// File: rtl/winreg_fwd.sv
// Per-read-port bypass: a same-cycle write to the read cell overrides RAM data.
module winreg_fwd #(
    parameter int IDX_W = 11,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] raddr,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    ram_q,
    output logic [DW-1:0]    rdata
);
    typedef struct packed {
        logic          hit;
        logic [DW-1:0] data;
    } fwd_t;

    fwd_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.hit  = we && (waddr == raddr);
        s_d.data = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.hit ? s_q.data : ram_q;

    // R3: a colliding write is what the port returns next cycle
    assert_fwd_new_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == raddr) |=> (rdata == $past(wdata)));
endmodule

// File: rtl/winreg_ctrl.sv
// Mode, window and trap control plus mapped-access decode.
module winreg_ctrl
    import winreg_pkg::*;
#(
    parameter int WIN_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mm_req_i,
    input  logic               mm_we_i,
    input  logic [1:0]         mm_lsb_i,
    input  logic               wr_en_i,
    input  logic               trap_take_i,
    input  logic               trap_ret_i,
    input  logic               ctx_load_i,
    input  logic [WIN_W-1:0]   ctx_win_i,
    output logic               accept_o,
    output logic               busy_o,
    output logic               ack_o,
    output logic               user_o,
    output logic [WIN_W-1:0]   cur_win_o,
    output logic [WIN_W-1:0]   saved_win_o,
    output logic               fault_o,
    output cause_e             cause_o
);
    typedef struct packed {
        logic             user;
        logic [WIN_W-1:0] cur;
        logic [WIN_W-1:0] saved;
        logic             fault;
        cause_e           cause;
        logic             ack;
    } ctl_t;

    ctl_t s_d, s_q;

    logic mm_misal, priv_f, align_f, fault_any, trap_any, ok_path;

    always_comb begin
        mm_misal  = (mm_lsb_i != 2'b00);
        priv_f    = mm_req_i && s_q.user;
        align_f   = mm_req_i && !s_q.user && mm_misal;
        fault_any = priv_f || align_f;
        trap_any  = fault_any || trap_take_i;
        ok_path   = mm_req_i && !s_q.user && !mm_misal;
        busy_o    = ok_path && mm_we_i && wr_en_i;
        accept_o  = ok_path && !(mm_we_i && wr_en_i);

        s_d       = s_q;
        s_d.fault = fault_any;
        s_d.ack   = accept_o;
        if (trap_any) begin
            s_d.saved = s_q.cur;
            s_d.cur   = '0;
            s_d.user  = 1'b0;
            if (priv_f)       s_d.cause = CAUSE_PRIV;
            else if (align_f) s_d.cause = CAUSE_ALIGN;
            else              s_d.cause = CAUSE_EXT;
        end else if (ctx_load_i && !s_q.user) begin
            s_d.saved = ctx_win_i;
        end else if (trap_ret_i && !s_q.user) begin
            s_d.cur  = s_q.saved;
            s_d.user = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ack_o       = s_q.ack;
    assign user_o      = s_q.user;
    assign cur_win_o   = s_q.cur;
    assign saved_win_o = s_q.saved;
    assign fault_o     = s_q.fault;
    assign cause_o     = s_q.cause;

    assert_fault_kernel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fault |-> (!s_q.user && s_q.cur == '0));
    assert_user_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_req_i && s_q.user) |=> (!s_q.ack && s_q.cause == CAUSE_PRIV));
    assert_align_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_req_i && !s_q.user && mm_misal) |=> (s_q.fault && s_q.cause == CAUSE_ALIGN));
    assert_busy_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !s_q.ack);
    assert_trap_save_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take_i |=> (s_q.cur == '0 && !s_q.user && s_q.saved == $past(s_q.cur)));
    assert_ret_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ret_i && !s_q.user && !trap_any && !ctx_load_i) |=>
        (s_q.user && s_q.cur == $past(s_q.saved)));
endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import winreg_pkg::*;
#(
    parameter int WIN_W = 6,
    parameter int DW    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [4:0]           rs1_idx_i,
    input  logic [4:0]           rs2_idx_i,
    output logic [DW-1:0]        rs1_data_o,
    output logic [DW-1:0]        rs2_data_o,
    input  logic                 wr_en_i,
    input  logic [4:0]           wr_idx_i,
    input  logic [DW-1:0]        wr_data_i,
    input  logic                 mm_req_i,
    input  logic                 mm_we_i,
    input  logic [WIN_W+6:0]     mm_addr_i,
    input  logic [DW-1:0]        mm_wdata_i,
    output logic                 mm_busy_o,
    output logic                 mm_ack_o,
    output logic [DW-1:0]        mm_rdata_o,
    input  logic                 trap_take_i,
    input  logic                 trap_ret_i,
    input  logic                 ctx_load_i,
    input  logic [WIN_W-1:0]     ctx_win_i,
    output logic                 user_mode_o,
    output logic [WIN_W-1:0]     cur_win_o,
    output logic [WIN_W-1:0]     saved_win_o,
    output logic                 fault_o,
    output logic [1:0]           cause_o
);
    localparam int IDX_W = WIN_W + 5;
    localparam int MAP_W = WIN_W + 7;
    localparam int NRD   = 3;

    logic                      mm_acc;
    cause_e                    cause_w;
    logic                      we_eff;
    logic [IDX_W-1:0]          waddr_eff;
    logic [DW-1:0]             wdata_eff;
    logic [NRD-1:0][IDX_W-1:0] raddr;
    logic [NRD-1:0][DW-1:0]    ram_q;
    logic [NRD-1:0][DW-1:0]    rd_out;

    winreg_ctrl #(.WIN_W(WIN_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mm_req_i    (mm_req_i),
        .mm_we_i     (mm_we_i),
        .mm_lsb_i    (mm_addr_i[1:0]),
        .wr_en_i     (wr_en_i),
        .trap_take_i (trap_take_i),
        .trap_ret_i  (trap_ret_i),
        .ctx_load_i  (ctx_load_i),
        .ctx_win_i   (ctx_win_i),
        .accept_o    (mm_acc),
        .busy_o      (mm_busy_o),
        .ack_o       (mm_ack_o),
        .user_o      (user_mode_o),
        .cur_win_o   (cur_win_o),
        .saved_win_o (saved_win_o),
        .fault_o     (fault_o),
        .cause_o     (cause_w)
    );

    assign cause_o = cause_w;

    // The single write port: the pipeline owns it, a mapped write only when free.
    always_comb begin
        we_eff    = wr_en_i || (mm_acc && mm_we_i);
        waddr_eff = wr_en_i ? {cur_win_o, wr_idx_i} : mm_addr_i[MAP_W-1:2];
        wdata_eff = wr_en_i ? wr_data_i : mm_wdata_i;
        raddr[0]  = {cur_win_o, rs1_idx_i};
        raddr[1]  = {cur_win_o, rs2_idx_i};
        raddr[2]  = mm_addr_i[MAP_W-1:2];
    end

    winreg_ram #(.IDX_W(IDX_W), .DW(DW), .NRD(NRD)) u_ram (
        .clk   (clk),
        .we    (we_eff),
        .waddr (waddr_eff),
        .wdata (wdata_eff),
        .raddr (raddr),
        .rdata (ram_q)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        winreg_fwd #(.IDX_W(IDX_W), .DW(DW)) u_fwd (
            .clk   (clk),
            .rst_n (rst_n),
            .raddr (raddr[p]),
            .we    (we_eff),
            .waddr (waddr_eff),
            .wdata (wdata_eff),
            .ram_q (ram_q[p]),
            .rdata (rd_out[p])
        );
    end

    assign rs1_data_o = rd_out[0];
    assign rs2_data_o = rd_out[1];
    assign mm_rdata_o = rd_out[2];

    // R7: the mapped path never writes while the pipeline writes
    assert_single_writer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && mm_acc && mm_we_i));
    // R2: pipeline port data follows the window active at request time
    assert_pipe_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && rs1_idx_i == wr_idx_i) |=> (rs1_data_o == $past(wr_data_i)));
endmodule

// File: tb/sim_winreg_file.sv
module sim_winreg_file;
    localparam int WIN_W = 6;
    localparam int CELLS = (1 << WIN_W) * 32;
    localparam int MAP_W = WIN_W + 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] rs1_idx, rs2_idx, wr_idx;
    logic [31:0] rs1_data, rs2_data, wr_data, mm_wdata, mm_rdata;
    logic wr_en, mm_req, mm_we, mm_busy, mm_ack;
    logic [MAP_W-1:0] mm_addr;
    logic trap_take, trap_ret, ctx_load, user_mode, fault;
    logic [WIN_W-1:0] ctx_win, cur_win, saved_win;
    logic [1:0] cause;

    always #5 clk = ~clk;

    winreg_file #(.WIN_W(WIN_W), .DW(32)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rs1_idx_i(rs1_idx), .rs2_idx_i(rs2_idx),
        .rs1_data_o(rs1_data), .rs2_data_o(rs2_data),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .mm_req_i(mm_req), .mm_we_i(mm_we), .mm_addr_i(mm_addr), .mm_wdata_i(mm_wdata),
        .mm_busy_o(mm_busy), .mm_ack_o(mm_ack), .mm_rdata_o(mm_rdata),
        .trap_take_i(trap_take), .trap_ret_i(trap_ret),
        .ctx_load_i(ctx_load), .ctx_win_i(ctx_win),
        .user_mode_o(user_mode), .cur_win_o(cur_win), .saved_win_o(saved_win),
        .fault_o(fault), .cause_o(cause)
    );

    logic [31:0] ref_mem [CELLS];
    logic m_user;
    logic [WIN_W-1:0] m_cur, m_saved;
    logic [1:0] m_cause;
    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic set_idle();
        wr_en = 0; mm_req = 0; mm_we = 0; trap_take = 0; trap_ret = 0; ctx_load = 0;
        rs1_idx = 0; rs2_idx = 0; wr_idx = 0; wr_data = 0;
        mm_addr = '0; mm_wdata = 0; ctx_win = '0;
    endtask

    function automatic logic [MAP_W-1:0] maddr(int win, int r);
        return MAP_W'((win << 7) | (r << 2));
    endfunction

    // One clock: predict from the model, then compare after the edge.
    task automatic cyc(string tag);
        logic priv, mis, alf, flt, acc, busy, trap, rd_ack;
        logic [31:0] e1, e2, em;
        #1;
        priv = mm_req && m_user;
        mis  = (mm_addr[1:0] != 2'b00);
        alf  = mm_req && !m_user && mis;
        flt  = priv || alf;
        busy = mm_req && !m_user && !mis && mm_we && wr_en;
        acc  = mm_req && !m_user && !mis && !(mm_we && wr_en);
        trap = flt || trap_take;
        rd_ack = acc && !mm_we;
        check(tag, "busy", 32'(mm_busy), 32'(busy));
        if (wr_en) ref_mem[{m_cur, wr_idx}] = wr_data;
        else if (acc && mm_we) ref_mem[mm_addr[MAP_W-1:2]] = mm_wdata;
        e1 = ref_mem[{m_cur, rs1_idx}];
        e2 = ref_mem[{m_cur, rs2_idx}];
        em = ref_mem[mm_addr[MAP_W-1:2]];
        if (trap) begin
            m_saved = m_cur; m_cur = '0; m_user = 0;
            m_cause = priv ? 2'd1 : (alf ? 2'd2 : 2'd3);
        end else if (ctx_load && !m_user) begin
            m_saved = ctx_win;
        end else if (trap_ret && !m_user) begin
            m_cur = m_saved; m_user = 1;
        end
        @(posedge clk);
        #1;
        check(tag, "rs1", rs1_data, e1);
        check(tag, "rs2", rs2_data, e2);
        check(tag, "ack", 32'(mm_ack), 32'(acc));
        if (rd_ack) check(tag, "mm_rdata", mm_rdata, em);
        check(tag, "fault", 32'(fault), 32'(flt));
        check(tag, "cause", 32'(cause), 32'(m_cause));
        check(tag, "user", 32'(user_mode), 32'(m_user));
        check(tag, "cur", 32'(cur_win), 32'(m_cur));
        check(tag, "saved", 32'(saved_win), 32'(m_saved));
        @(negedge clk);
    endtask

    task automatic mm_op(logic we, logic [MAP_W-1:0] a, logic [31:0] d, string tag);
        set_idle(); mm_req = 1; mm_we = we; mm_addr = a; mm_wdata = d;
        cyc(tag); set_idle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        set_idle();
        m_user = 0; m_cur = '0; m_saved = '0; m_cause = 2'd0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        check("R1", "user", 32'(user_mode), 0);
        check("R1", "cur", 32'(cur_win), 0);
        check("R1", "saved", 32'(saved_win), 0);
        check("R1", "fault", 32'(fault), 0);
        check("R1", "ack", 32'(mm_ack), 0);
        @(negedge clk);

        // R4: fill every cell through the mapped path
        for (int i = 0; i < CELLS; i++)
            mm_op(1'b1, MAP_W'(i << 2), 32'(i) * 32'h0101_0107 ^ 32'hA5A5_0000, "R4");
        mm_op(1'b0, maddr(7, 13), 0, "R4");
        mm_op(1'b0, maddr(63, 31), 0, "R4");
        mm_op(1'b0, maddr(1, 0), 0, "R4");

        // R3: kernel pipeline write read in the same cycle
        set_idle(); wr_en = 1; wr_idx = 5'd3; wr_data = 32'hDEAD_BEEF;
        rs1_idx = 5'd3; rs2_idx = 5'd4; cyc("R3"); set_idle();

        // R9: load return window, then enter the task
        set_idle(); ctx_load = 1; ctx_win = 6'd5; cyc("R9");
        set_idle(); trap_ret = 1; cyc("R9");
        // R2: user reads see window 5 contents written through the map
        set_idle(); rs1_idx = 5'd9; rs2_idx = 5'd31; cyc("R2");
        set_idle(); wr_en = 1; wr_idx = 5'd9; wr_data = 32'h1234_5678; rs2_idx = 5'd9; cyc("R3");
        // R9: ignored in user mode
        set_idle(); ctx_load = 1; ctx_win = 6'd9; cyc("R9");
        set_idle(); trap_ret = 1; cyc("R9");

        // R5: user mapped write is blocked and traps
        mm_op(1'b1, maddr(2, 6), 32'hBAD0_0001, "R5");
        mm_op(1'b0, maddr(2, 6), 0, "R5");
        // R6: misaligned kernel access
        mm_op(1'b1, maddr(2, 7) | 2'b10, 32'hBAD0_0002, "R6");
        mm_op(1'b0, maddr(2, 7), 0, "R6");
        // R7: mapped write collides with pipeline write
        set_idle(); mm_req = 1; mm_we = 1; mm_addr = maddr(0, 4); mm_wdata = 32'hBAD0_0003;
        wr_en = 1; wr_idx = 5'd4; wr_data = 32'h0000_7777; cyc("R7");
        mm_op(1'b0, maddr(0, 4), 0, "R7");
        mm_op(1'b1, maddr(0, 4), 32'h0000_8888, "R7");
        mm_op(1'b0, maddr(0, 4), 0, "R7");

        // R8: external trap from a user task
        set_idle(); ctx_load = 1; ctx_win = 6'd12; cyc("R8");
        set_idle(); trap_ret = 1; cyc("R8");
        set_idle(); trap_take = 1; cyc("R8");
        // R10: trap beats return, fault cause beats external
        set_idle(); trap_take = 1; trap_ret = 1; ctx_load = 1; ctx_win = 6'd3; cyc("R10");
        set_idle(); trap_ret = 1; cyc("R10");
        set_idle(); trap_take = 1; mm_req = 1; mm_addr = maddr(4, 4); cyc("R10");

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            set_idle();
            rs1_idx = 5'($urandom); rs2_idx = 5'($urandom);
            wr_en = ($urandom % 100) < 40; wr_idx = 5'($urandom); wr_data = $urandom;
            mm_req = ($urandom % 100) < 35; mm_we = $urandom % 2;
            mm_addr = MAP_W'($urandom);
            if (($urandom % 10) != 0) mm_addr[1:0] = 2'b00;
            mm_wdata = $urandom;
            trap_take = ($urandom % 100) < 3;
            trap_ret = ($urandom % 100) < 8;
            ctx_load = ($urandom % 100) < 6; ctx_win = WIN_W'($urandom);
            cyc("R2");
        end
        set_idle();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule